// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a regular interrupt from the processor clock. A prescaler divides the clock by a programmed ratio. Each time the prescaler wraps, it issues a tick, and each tick moves a 16-bit down-counter one step lower. A tick that finds the counter at zero does two things: it sends out a one-cycle interrupt pulse, and it refills the counter from a 16-bit period register. The timer therefore fires every (period + 1) ticks for as long as it runs.

Software programs the block through a single write port. A two-bit select chooses the scale, period or count register. A separate run input starts and freezes the timer. The present count value is always visible on an output, so software can read how far the current interval has progressed.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset, the count output is 0, the interrupt output is low, and both the scale and period registers are 0.
- R2: A write stores data into the register that the select chooses. Select 0 is the scale register and takes data bits 7:0. Select 1 is the period register. Select 2 is the count register. A write with select 3 has no effect on any register.
- R3: With a scale value s and run held high, a tick occurs once every s+1 cycles. Scale 0 gives a tick on every cycle, and scale 255 gives a tick every 256 cycles.
- R4: A tick that finds a nonzero count lowers the count by exactly one.
- R5: A tick that finds the count at zero loads the count from the period register. The interrupt output is high for the one cycle that follows that clock edge, and it is high at no other time.
- R6: A count write sets the count output to the written value on the next cycle and restarts the prescaler. If a tick would fall on the same edge, the write takes priority: there is no decrement, no reload and no interrupt.
- R7: While run is low, the count and the prescaler keep their values and no interrupt is raised. Register writes still apply.
- R8: A period write does not change the current count. The new period is used at the next reload.
- R9: If a scale write lowers the scale below the prescaler's current position, the next enabled cycle produces a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 scale, 1 period, 2 count, 3 none |
| wrData | input | 16 | Write data |
| runEn | input | 1 | Timer runs while high |
| tickIrq | output | 1 | Interrupt pulse, high one cycle per reload |
| countVal | output | 16 | Current count value |

## Verification
A software count write can land on the same clock edge as a tick that finds the count at zero. That single edge asks for both a load and a reload with an interrupt. The bench sets this up at scale 0 by letting the count run down to zero and then driving the count write during the cycle just before the edge that would reload. It then expects the written value on the output, no interrupt pulse, and a normal decrement on the edge after that. A second overlap is also covered: a scale write that arrives while the prescaler is already past the new limit, which must produce a tick on the very next enabled edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    SEL_SCALE  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldScale;
    logic ldPeriod;
    logic ldCount;
    logic reload;
    logic decr;
  } pitStrobe_t;

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pitStrobe_t         strb,
  input  logic [COUNT_W-1:0] wrData,
  output logic [SCALE_W-1:0] scaleQ,
  output logic [COUNT_W-1:0] countQ,
  output logic               countZero
);

  logic [COUNT_W-1:0] periodQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaleQ <= '0;
    end else if (strb.ldScale) begin
      scaleQ <= wrData[SCALE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodQ <= '0;
    end else if (strb.ldPeriod) begin
      periodQ <= wrData;
    end
  end

  // load wins over reload, reload over decrement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.ldCount) begin
      countQ <= wrData;
    end else if (strb.reload) begin
      countQ <= periodQ;
    end else if (strb.decr) begin
      countQ <= countQ - COUNT_W'(1);
    end
  end

  assign countZero = (countQ == '0);

endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic               runEn,
  input  logic [SCALE_W-1:0] scaleQ,
  input  logic               countZero,
  output pitStrobe_t         strb,
  output logic               irqQ
);

  logic [SCALE_W-1:0] presCnt;
  logic               tick;
  regSel_e            sel;

  assign sel = regSel_e'(wrSel);

  always_comb begin
    strb          = '0;
    strb.ldScale  = wrEn && (sel == SEL_SCALE);
    strb.ldPeriod = wrEn && (sel == SEL_PERIOD);
    strb.ldCount  = wrEn && (sel == SEL_COUNT);
    // >= so that a shrunk scale still wraps at once
    tick          = runEn && (presCnt >= scaleQ) && !strb.ldCount;
    strb.reload   = tick && countZero;
    strb.decr     = tick && !countZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (strb.ldCount) begin
      presCnt <= '0;
    end else if (runEn) begin
      presCnt <= tick ? '0 : presCnt + SCALE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else begin
      irqQ <= strb.reload;
    end
  end

endmodule

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer
  import pit_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [COUNT_W-1:0] wrData,
  input  logic               runEn,
  output logic               tickIrq,
  output logic [COUNT_W-1:0] countVal
);

  pitStrobe_t         strb;
  logic [SCALE_W-1:0] scaleQ;
  logic               countZero;

  pit_control #(.SCALE_W(SCALE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .runEn     (runEn),
    .scaleQ    (scaleQ),
    .countZero (countZero),
    .strb      (strb),
    .irqQ      (tickIrq)
  );

  pit_datapath #(.COUNT_W(COUNT_W), .SCALE_W(SCALE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .scaleQ    (scaleQ),
    .countQ    (countVal),
    .countZero (countZero)
  );

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         wrSel,
  input logic [COUNT_W-1:0] wrData,
  input logic               runEn,
  input logic               tickIrq,
  input logic [COUNT_W-1:0] countVal
);

  logic cntWr;
  assign cntWr = wrEn && (wrSel == 2'd2);

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (countVal == $past(wrData)) && !tickIrq); // R6

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWr) |=> $stable(countVal) && !tickIrq); // R7

  AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> ($past(countVal) == '0) && $past(runEn)); // R5

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !cntWr && countVal != '0) |=>
      (countVal == $past(countVal)) || (countVal == $past(countVal) - COUNT_W'(1))); // R4

endmodule

bind prescaled_interval_timer pit_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .runEn    (runEn),
  .tickIrq  (tickIrq),
  .countVal (countVal)
);

// File: tb/prescaled_interval_timer_tb.sv
module prescaled_interval_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [15:0] wrData = '0;
  logic        runEn = 1'b0;
  logic        tickIrq;
  logic [15:0] countVal;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  prescaled_interval_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .runEn(runEn), .tickIrq(tickIrq), .countVal(countVal)
  );

  // scale, period, count, run cycles, expected count, expected interrupts
  localparam int NV = 9;
  localparam int VEC [NV][6] = '{
    '{0,   5,     3, 2,   1,     0},
    '{0,   5,     3, 4,   5,     1},
    '{0,   4,     2, 20,  2,     4},
    '{3,   10,    7, 20,  2,     0},
    '{1,   2,     0, 9,   2,     2},
    '{2,   0,     1, 12,  0,     3},
    '{255, 1,     1, 512, 1,     1},
    '{255, 1,     1, 511, 0,     0},
    '{0,   65535, 0, 1,   65535, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(input int s, input int p, input int c);
    runEn = 1'b0;
    wr(2'd0, s);
    wr(2'd1, p);
    wr(2'd2, c);
  endtask

  task automatic run(input int n, output int irqs);
    irqs = 0;
    runEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tickIrq) irqs++;
    end
    runEn = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int irqs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset count", int'(countVal), 0);
    chk("R1 reset irq", int'(tickIrq), 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2]);
      run(VEC[v][3], irqs);
      chk($sformatf("R3/R4 vec%0d count", v), int'(countVal), VEC[v][4]);
      chk($sformatf("R5 vec%0d irqs", v), irqs, VEC[v][5]);
    end

    // R7 hold while disabled
    setup(0, 100, 9);
    run(3, irqs);
    chk("R7 running count", int'(countVal), 6);
    irqs = 0;
    repeat (5) begin
      @(negedge clk);
      if (tickIrq) irqs++;
    end
    chk("R7 held count", int'(countVal), 6);
    chk("R7 no irq", irqs, 0);

    // R2 select 3 ignored
    wr(2'd3, 1234);
    chk("R2 sel3 count", int'(countVal), 6);
    run(1, irqs);
    chk("R2 sel3 scale kept", int'(countVal), 5);

    // R6 count write coincides with zero-reach tick
    setup(0, 50, 2);
    runEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 before collide", int'(countVal), 0);
    wrEn = 1'b1; wrSel = 2'd2; wrData = 16'd7;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R6 write wins count", int'(countVal), 7);
    chk("R6 no irq", int'(tickIrq), 0);
    @(negedge clk);
    chk("R6 then decrement", int'(countVal), 6);
    runEn = 1'b0;

    // R8 period write mid-run
    setup(0, 3, 2);
    runEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd1; wrData = 16'd8;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R8 count untouched", int'(countVal), 0);
    @(negedge clk);
    chk("R8 new period used", int'(countVal), 8);
    chk("R8 irq on reload", int'(tickIrq), 1);
    @(negedge clk);
    chk("R5 single pulse", int'(tickIrq), 0);
    runEn = 1'b0;

    // R9 scale shrink below prescaler position
    setup(10, 40, 20);
    runEn = 1'b1;
    repeat (5) @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd0; wrData = 16'd2;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R9 no tick yet", int'(countVal), 20);
    @(negedge clk);
    chk("R9 immediate tick", int'(countVal), 19);
    runEn = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule